// File: doc/BRIEF.md
# Auto-Stepping Video Memory Data Port

This block sits between a CPU register bus and a synchronous video memory. It keeps a 14-bit pointer into that memory. Software loads the pointer by writing two bytes to an address register. It then moves bytes through a data register. After every data access, read or write, the pointer moves forward by itself. One bit of a control register sets the stride to 1 byte or 32 bytes. With a 32-byte stride, successive writes go down a column of 32-byte tile rows, so a full tile column can be loaded without reloading the pointer.

The stride ignores the memory map. It never skips attribute bytes or row ends. It adds 1 or 32 and wraps at 0x4000. Data reads go through a one-deep buffer: a read returns the byte the buffer already holds, and the buffer then refills from the location that was just addressed. Reading the status register resets the two-write address sequence, so the next address write is taken as the high byte.

Top module: `vram_access_port`

## Requirements
- R1: After reset, the pointer is 0x0000, the stride is 1, the address sequence expects a high byte, the read buffer and `cpuRdata` are 0x00, and `vramWe` is low.
- R2: Register index 2 is the address register. The first write after a reset of the sequence keeps bits 5:0 as pointer bits 13:8 and drops bits 7:6. The second write supplies pointer bits 7:0. The pointer changes only on the second write, and the two writes alternate.
- R3: A read of register index 1 (status) returns 0x00 in `cpuRdata` on the following cycle and resets the address sequence, so the next address write is treated as a high byte.
- R4: A write to register index 3 (data) raises `vramWe` in that same cycle, with `vramAddr` equal to the pointer and `vramWdata` equal to the CPU byte.
- R5: Every data read or write advances the pointer by 1 when bit 2 of the last byte written to register index 0 (control) is 0, and by 32 when it is 1. The other control bits have no effect.
- R6: Pointer arithmetic is modulo 0x4000 with no region skipping. From 0x3FFF a stride of 1 gives 0x0000, and from 0x3FE5 a stride of 32 gives 0x0005.
- R7: A data read presents the current pointer on `vramAddr`. One cycle later, `cpuRdata` shows the byte the buffer held before the read. The buffer then takes the memory byte at the address that was read. The first data read after reset returns 0x00.
- R8: Data reads on consecutive cycles each return the byte fetched by the read before them.
- R9: Data writes do not change the read buffer.
- R10: Cycles with no access, and accesses to control or address-high, leave the pointer unchanged and keep `vramWe` low. A data write is the only thing that raises `vramWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | A register access takes place this cycle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuReg | input | 2 | Register index: 0 control, 1 status, 2 address, 3 data |
| cpuWdata | input | 8 | Byte written by the CPU |
| cpuRdata | output | 8 | Byte returned for the previous status or data read |
| vramAddr | output | 14 | Memory address (the current pointer) |
| vramWdata | output | 8 | Byte to store in memory |
| vramWe | output | 1 | Memory write enable |
| vramRdata | input | 8 | Memory byte, valid one cycle after its address |

## Verification
The assertions assume that the memory returns the byte for an address exactly one cycle after that address is presented. They also assume one register access per cycle, selected by a single index. The bench uses a memory model with exactly that latency and drives one operation per clock. Random mixes of back-to-back reads, writes, stride changes, half-finished address loads and status reads stay within these limits, so every property is meaningful on every cycle after reset.

// File: rtl/vram_access_pkg.sv
package vram_access_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_ADDR   = 2'd2,
    REG_DATA   = 2'd3
  } regSel_e;

  // One-hot strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic ctrlWr;
    logic statusRd;
    logic addrHiWr;
    logic addrLoWr;
    logic dataWr;
    logic dataRd;
  } portStrobes_t;

endpackage

// File: rtl/vap_ctrl.sv
module vap_ctrl
  import vram_access_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuSel,
  input  logic         cpuWe,
  input  logic [1:0]   cpuReg,
  output portStrobes_t strobes
);

  regSel_e regSel;
  logic    latchPhase;   // 0: next address write is the high byte
  logic    addrWr;

  assign regSel = regSel_e'(cpuReg);
  assign addrWr = cpuSel && cpuWe && (regSel == REG_ADDR);

  always_comb begin
    strobes          = '0;
    strobes.ctrlWr   = cpuSel &&  cpuWe && (regSel == REG_CTRL);
    strobes.statusRd = cpuSel && !cpuWe && (regSel == REG_STATUS);
    strobes.addrHiWr = addrWr && !latchPhase;
    strobes.addrLoWr = addrWr &&  latchPhase;
    strobes.dataWr   = cpuSel &&  cpuWe && (regSel == REG_DATA);
    strobes.dataRd   = cpuSel && !cpuWe && (regSel == REG_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchPhase <= 1'b0;
    end else if (strobes.statusRd) begin
      latchPhase <= 1'b0;
    end else if (addrWr) begin
      latchPhase <= ~latchPhase;
    end
  end

  // R3: a status read leaves the sequence expecting a high byte
  p_phase_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.statusRd |=> !latchPhase);

  // R2: address writes alternate between high and low byte
  p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.addrHiWr || strobes.addrLoWr) |=> (latchPhase != $past(latchPhase)));

  // R10: at most one strobe per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/vap_datapath.sv
module vap_datapath
  import vram_access_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int ROW_STEP = 32,
  parameter int STEP_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] vramRdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [DATA_W-1:0] vramWdata,
  output logic              vramWe
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] BIG_STEP   = ADDR_W'(ROW_STEP);
  localparam logic [ADDR_W-1:0] SMALL_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pointer;
  logic [HI_W-1:0]   hiHold;
  logic              stepLarge;
  logic [DATA_W-1:0] readBuf;
  logic              fillPending;
  logic [DATA_W-1:0] cpuRdataQ;
  logic [ADDR_W-1:0] stepVal;
  logic [DATA_W-1:0] readBack;
  logic              dataAccess;

  assign dataAccess = strobes.dataRd || strobes.dataWr;
  assign stepVal    = stepLarge ? BIG_STEP : SMALL_STEP;
  // The byte fetched by the previous read arrives in this cycle when pending.
  assign readBack   = fillPending ? vramRdata : readBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pointer   <= '0;
      hiHold    <= '0;
      stepLarge <= 1'b0;
    end else begin
      if (strobes.ctrlWr)   stepLarge <= cpuWdata[STEP_BIT];
      if (strobes.addrHiWr) hiHold    <= cpuWdata[HI_W-1:0];
      if (strobes.addrLoWr)        pointer <= {hiHold, cpuWdata};
      else if (dataAccess)         pointer <= pointer + stepVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readBuf     <= '0;
      fillPending <= 1'b0;
      cpuRdataQ   <= '0;
    end else begin
      fillPending <= strobes.dataRd;
      if (fillPending)           readBuf   <= vramRdata;
      if (strobes.dataRd)        cpuRdataQ <= readBack;
      else if (strobes.statusRd) cpuRdataQ <= '0;
    end
  end

  assign cpuRdata  = cpuRdataQ;
  assign vramAddr  = pointer;
  assign vramWdata = cpuWdata;
  assign vramWe    = strobes.dataWr;

  // R5/R6: a data access moves the address by exactly one stride
  p_stride_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataAccess |=> (vramAddr == ($past(vramAddr) +
                    ($past(stepLarge) ? BIG_STEP : SMALL_STEP))));

  // R10: with no data access and no low-byte write the address holds
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(dataAccess || strobes.addrLoWr) |=> $stable(vramAddr));

  // R7: a read always schedules a refill of the buffer
  p_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataRd |=> fillPending);

  // R9: a write never disturbs the buffer when no fill is due
  p_wr_keeps_buf_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataWr && !fillPending) |=> $stable(readBuf));

  // R8: an unpending read returns the stored buffer byte
  p_rd_return_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataRd && !fillPending) |=> (cpuRdata == $past(readBuf)));

endmodule

// File: rtl/vram_access_port.sv
module vram_access_port
  import vram_access_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int ROW_STEP = 32,
  parameter int STEP_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [1:0]        cpuReg,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [DATA_W-1:0] vramWdata,
  output logic              vramWe,
  input  logic [DATA_W-1:0] vramRdata
);

  portStrobes_t strobes;

  vap_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cpuSel (cpuSel),
    .cpuWe  (cpuWe),
    .cpuReg (cpuReg),
    .strobes(strobes)
  );

  vap_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ROW_STEP(ROW_STEP),
    .STEP_BIT(STEP_BIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cpuWdata (cpuWdata),
    .vramRdata(vramRdata),
    .cpuRdata (cpuRdata),
    .vramAddr (vramAddr),
    .vramWdata(vramWdata),
    .vramWe   (vramWe)
  );

  // R4: memory writes happen only on CPU write cycles
  p_we_needs_cpu_r4: assert property (@(posedge clk) disable iff (!rstN)
    vramWe |-> (cpuSel && cpuWe));

endmodule

// File: tb/vram_access_port_tb_top.sv
module vram_access_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuSel;
  logic        cpuWe;
  logic [1:0]  cpuReg;
  logic [7:0]  cpuWdata;
  logic [7:0]  cpuRdata;
  logic [13:0] vramAddr;
  logic [7:0]  vramWdata;
  logic        vramWe;
  logic [7:0]  vramRdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  vram_access_port dut_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuReg(cpuReg),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .vramAddr(vramAddr),
    .vramWdata(vramWdata), .vramWe(vramWe), .vramRdata(vramRdata)
  );

  // Memory contents before any write
  function automatic logic [7:0] initByte(input logic [13:0] a);
    return 8'(a * 7 + 3) ^ 8'(a >> 8);
  endfunction

  // Memory model with one cycle of read latency, written by the DUT
  logic [7:0] vmem [int];
  always @(posedge clk) begin
    vramRdata <= vmem.exists(int'(vramAddr)) ? vmem[int'(vramAddr)] : initByte(vramAddr);
    if (vramWe) vmem[int'(vramAddr)] = vramWdata;
  end

  // Reference state, derived from the requirements only
  logic [7:0]  shadow [int];
  logic [13:0] mPtr;
  logic [5:0]  mHold;
  logic        mPhase;
  logic        mStep32;
  logic [7:0]  mBuf;
  logic        pendRead;
  logic [7:0]  pendVal;
  string       pendReq;

  function automatic logic [7:0] shadowRd(input logic [13:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : initByte(a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One operation per cycle: drive at the falling edge, check the result one cycle later
  task automatic doOp(input bit sel, input bit we, input logic [1:0] rg,
                      input logic [7:0] d, input string req);
    @(negedge clk);
    if (pendRead) chk(cpuRdata == pendVal, pendReq, cpuRdata, pendVal);
    pendRead = 1'b0;
    cpuSel = sel; cpuWe = we; cpuReg = rg; cpuWdata = d;
    #1;
    if (sel && rg == 2'd3 && we) begin
      chk(vramWe == 1'b1, {req, " R4 we"}, vramWe, 1);
      chk(vramAddr == mPtr, {req, " R4 addr"}, vramAddr, mPtr);
      chk(vramWdata == d, "R4 wdata", vramWdata, d);
      shadow[int'(mPtr)] = d;
      mPtr = mPtr + (mStep32 ? 14'd32 : 14'd1);
    end else begin
      chk(vramWe == 1'b0, "R10 we low", vramWe, 0);
      if (sel && rg == 2'd3) begin
        chk(vramAddr == mPtr, {req, " R5 rd addr"}, vramAddr, mPtr);
        pendRead = 1'b1; pendVal = mBuf; pendReq = {req, " R7 rdata"};
        mBuf = shadowRd(mPtr);
        mPtr = mPtr + (mStep32 ? 14'd32 : 14'd1);
      end else if (sel && rg == 2'd1 && !we) begin
        pendRead = 1'b1; pendVal = 8'h00; pendReq = "R3 status";
        mPhase = 1'b0;
      end else if (sel && rg == 2'd0 && we) begin
        mStep32 = d[2];
      end else if (sel && rg == 2'd2 && we) begin
        if (!mPhase) mHold = d[5:0];
        else         mPtr = {mHold, d};
        mPhase = ~mPhase;
      end
    end
  endtask

  task automatic setAddr(input logic [13:0] a);
    doOp(1, 0, 2'd1, 8'h00, "R3");
    doOp(1, 1, 2'd2, {2'b00, a[13:8]}, "R2");
    doOp(1, 1, 2'd2, a[7:0], "R2");
  endtask

  task automatic idle();
    doOp(0, 0, 2'd0, 8'h00, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; cpuSel = 0; cpuWe = 0; cpuReg = 0; cpuWdata = 0;
    mPtr = 0; mHold = 0; mPhase = 0; mStep32 = 0; mBuf = 0; pendRead = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state at the ports
    chk(cpuRdata == 8'h00, "R1 rdata", cpuRdata, 0);
    chk(vramAddr == 14'h0, "R1 addr", vramAddr, 0);
    chk(vramWe == 1'b0, "R1 we", vramWe, 0);

    // R7: first read returns the empty buffer, the second the fetched byte
    setAddr(14'h0123);
    doOp(1, 0, 2'd3, 0, "R7 first");
    doOp(1, 0, 2'd3, 0, "R8 b2b");
    doOp(1, 0, 2'd3, 0, "R8 b2b");
    idle();

    // R2: a lone high byte does not move the pointer; a status read restarts the pair
    doOp(1, 1, 2'd2, 8'h15, "R2 hi only");
    doOp(1, 0, 2'd1, 0, "R3 clear");
    doOp(1, 1, 2'd3, 8'hA1, "R2 unchanged");
    // R2: bits 7:6 of the high byte are dropped; R6: wrap at 0x3FFF with stride 1
    doOp(1, 1, 2'd2, 8'hFF, "R2 hi");
    doOp(1, 1, 2'd2, 8'hFF, "R2 lo");
    doOp(1, 1, 2'd3, 8'h11, "R6 top");
    doOp(1, 1, 2'd3, 8'h22, "R6 wrap1");

    // R5/R6: stride 32 down a column, wrapping 0x3FE5 -> 0x0005
    doOp(1, 1, 2'd0, 8'h04, "R5 ctrl");
    setAddr(14'h3FE5);
    doOp(1, 1, 2'd3, 8'h33, "R6 col");
    doOp(1, 1, 2'd3, 8'h44, "R6 wrap32");
    doOp(1, 1, 2'd3, 8'h55, "R5 col");
    // R5: the other control bits leave the stride at 1
    doOp(1, 1, 2'd0, 8'hFB, "R5 ctrl");
    doOp(1, 1, 2'd3, 8'h66, "R5 step1");
    doOp(1, 1, 2'd3, 8'h77, "R5 step1");

    // R9: a write between reads leaves the buffer alone; reading back written data
    setAddr(14'h0005);
    doOp(1, 0, 2'd3, 0, "R9 prime");
    doOp(1, 1, 2'd3, 8'h99, "R9 wr");
    doOp(1, 0, 2'd3, 0, "R9 buf kept");
    idle();

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 16);
      d = 8'($urandom);
      if (r < 6)       doOp(1, 1, 2'd3, d, "R4 rnd");
      else if (r < 11) doOp(1, 0, 2'd3, d, "R8 rnd");
      else if (r == 11) doOp(1, 1, 2'd0, d, "R5 rnd");
      else if (r < 14) doOp(1, 1, 2'd2, d, "R2 rnd");
      else if (r == 14) doOp(1, 0, 2'd1, d, "R3 rnd");
      else             doOp(r[0], 0, 2'd0, d, "R10 rnd");
    end
    idle();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule